// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the module clock into time quanta and walks every nominal bit through four segments in a fixed order: a one-quantum synchronization segment, then a propagation segment, then phase 1, then phase 2. It pulses `sample_pt` in the cycle that closes phase 1, which is the point where the receive path should latch the bus level. It pulses `tx_pt` in the cycle that closes phase 2, which is where the next bit begins and the transmit path should drive its next level. The bus level is active low: logic 0 on `rx` is dominant and logic 1 is recessive.

Software sets the prescaler, the three programmable segment lengths and the synchronization jump width while `config_mode` is high. The block captures them and checks that they are legal. An illegal setting holds the block idle and raises `config_error`. At run time, a recessive-to-dominant edge while `bus_idle` is high restarts the bit at once (hard synchronization). The same edge while the bus is busy moves the bit boundary by at most the jump width (resynchronization), which absorbs clock drift between nodes.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2×(brp+1) clock cycles, and a whole bit lasts (1+prop+ph1+ph2) quanta. This is measured as the cycle distance between consecutive `tx_pt` pulses when there are no edges on `rx`.
- R2: `sample_pt` is high in the cycle that ends phase 1. This is (1+prop+ph1) quanta, counted in cycles, after the cycle in which `tx_pt` was high.
- R3: A setting is legal only when all of the following hold. Prop, ph1 and ph2 each lie in 1..8. Sjw is at least 1. The total 1+prop+ph1+ph2 lies in 8..25. Prop+ph1 ≥ ph2. Ph2 > sjw. `config_error` is 1 exactly when the captured setting breaks any of these rules.
- R4: While `config_mode` is high, or while `config_error` is 1, neither `sample_pt` nor `tx_pt` ever pulses.
- R5: The setting inputs are captured only on clock edges where `config_mode` is high. Changes to them while `config_mode` is low have no effect on bit timing or on `config_error`.
- R6: After reset the captured setting is all zero, so `config_error` reads 1 and no strobe pulses.
- R7: A falling edge on `rx` (1 then 0 on consecutive clock edges) while `bus_idle` is 1 restarts the bit at the synchronization segment. Counting the clock edge that first sees `rx` low as edge 0, `sample_pt` is high in the cycle after edge (1+prop+ph1)·TQ−1 and `tx_pt` in the cycle after edge NBT·TQ−1. Here TQ is the quantum in cycles and NBT is the bit length in quanta.
- R8: A falling edge while `bus_idle` is 0, seen during the propagation segment or phase 1, lengthens phase 1 by min(e, sjw) quanta. The error e is the number of quanta since the end of the synchronization segment, counting the current one.
- R9: A falling edge while `bus_idle` is 0, seen during phase 2, shortens phase 2 by min(r, sjw) quanta. The value r is the number of phase 2 quanta left, counting the current one.
- R10: A falling edge seen during the synchronization segment, and any rising edge on `rx`, leave the bit timing unchanged.
- R11: `sample_pt` and `tx_pt` are single-cycle pulses that fall on a quantum boundary, and they are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| config_mode | input | 1 | High: capture the setting inputs and hold the block idle |
| cfg_brp | input | BRP_W | Prescaler value; quantum = 2×(cfg_brp+1) cycles |
| cfg_prop | input | 4 | Propagation segment length in quanta |
| cfg_ph1 | input | 4 | Phase 1 length in quanta |
| cfg_ph2 | input | 4 | Phase 2 length in quanta |
| cfg_sjw | input | 4 | Synchronization jump width in quanta |
| rx | input | 1 | Bus receive level (0 dominant) |
| bus_idle | input | 1 | High while no frame is in progress |
| sample_pt | output | 1 | Pulse at the end of phase 1 |
| tx_pt | output | 1 | Pulse at the end of phase 2 (bit boundary) |
| config_error | output | 1 | Captured setting is illegal |

## Verification
The hardest cases to reach are the resynchronization rules, because the effect depends on which segment and which quantum an edge lands in. Hitting these cases from the pins means placing a single `rx` fall inside a chosen quantum. The bench aligns to a `tx_pt` pulse and counts clock edges from there. It computes the edge position from the programmed segment lengths, so the fall lands in the synchronization segment, the propagation segment, the first quantum of phase 1, or the first quantum of phase 2. It then checks that the following bit boundary moves by exactly min(error, sjw) quanta. Hard synchronization uses the same counting, started from the edge that sees `rx` low.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
   localparam int SEG_W   = 4;          // width of each segment length field
   localparam int QC_W    = SEG_W + 1;  // quantum counters and sums
   localparam int SEG_MIN = 1;
   localparam int SEG_MAX = 8;
   localparam int NBT_MIN = 8;
   localparam int NBT_MAX = 25;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PROP = 2'd1,
      SEG_PH1  = 2'd2,
      SEG_PH2  = 2'd3
   } seg_e;

   typedef struct packed {
      logic [SEG_W-1:0] prop;
      logic [SEG_W-1:0] ph1;
      logic [SEG_W-1:0] ph2;
      logic [SEG_W-1:0] sjw;
   } seg_cfg_t;
endpackage

// File: rtl/cbt_cfg_latch.sv
module cbt_cfg_latch
   import cbt_pkg::*;
#(
   parameter int BRP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BRP_W-1:0] brp_in,
   input  seg_cfg_t         seg_in,
   output logic [BRP_W-1:0] brp_q,
   output seg_cfg_t         seg_q,
   output logic             bad
);
   localparam int SUM_W = QC_W + 1;

   logic [SUM_W-1:0] nbt;
   logic [SUM_W-1:0] early;
   logic             range_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brp_q <= '0;
         seg_q <= '0;
      end else if (load) begin
         brp_q <= brp_in;
         seg_q <= seg_in;
      end
   end

   always_comb begin
      nbt   = SUM_W'(1) + SUM_W'(seg_q.prop) + SUM_W'(seg_q.ph1) + SUM_W'(seg_q.ph2);
      early = SUM_W'(seg_q.prop) + SUM_W'(seg_q.ph1);
      range_bad = (seg_q.prop < SEG_W'(SEG_MIN)) || (seg_q.prop > SEG_W'(SEG_MAX)) ||
                  (seg_q.ph1  < SEG_W'(SEG_MIN)) || (seg_q.ph1  > SEG_W'(SEG_MAX)) ||
                  (seg_q.ph2  < SEG_W'(SEG_MIN)) || (seg_q.ph2  > SEG_W'(SEG_MAX)) ||
                  (seg_q.sjw  < SEG_W'(1));
      bad = range_bad ||
            (nbt < SUM_W'(NBT_MIN)) || (nbt > SUM_W'(NBT_MAX)) ||
            (early < SUM_W'(seg_q.ph2)) ||
            (seg_q.ph2 <= seg_q.sjw);
   end
endmodule

// File: rtl/cbt_tq_div.sv
module cbt_tq_div #(
   parameter int BRP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [BRP_W-1:0] brp,
   output logic             tick
);
   localparam int CNT_W = BRP_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   assign lim  = {brp, 1'b1};           // 2*(brp+1) - 1
   assign tick = run && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!run || restart)   cnt <= '0;
      else if (tick)              cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/cbt_seg_seq.sv
module cbt_seg_seq
   import cbt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  logic     tick,
   input  logic     fall_edge,
   input  logic     bus_idle,
   input  seg_cfg_t cfg,
   output logic     hard_sync,
   output logic     sample_pt,
   output logic     tx_pt
);
   seg_e            seg;
   logic [QC_W-1:0] qcnt;
   logic [QC_W-1:0] ext;
   logic [QC_W-1:0] shrink;
   logic            done;
   logic [QC_W-1:0] seg_len;
   logic [QC_W-1:0] err_q;
   logic [QC_W-1:0] adj;
   logic            last_q;
   logic            seg_done;
   logic            resync;

   assign hard_sync = run && fall_edge && bus_idle;
   assign resync    = run && fall_edge && !bus_idle && !done && (seg != SEG_SYNC);

   always_comb begin
      unique case (seg)
         SEG_SYNC: seg_len = QC_W'(1);
         SEG_PROP: seg_len = QC_W'(cfg.prop);
         SEG_PH1:  seg_len = QC_W'(cfg.ph1) + ext;
         default:  seg_len = QC_W'(cfg.ph2) - shrink;
      endcase
      unique case (seg)
         SEG_PROP: err_q = qcnt + 1'b1;
         SEG_PH1:  err_q = QC_W'(cfg.prop) + qcnt + 1'b1;
         SEG_PH2:  err_q = QC_W'(cfg.ph2) - qcnt;
         default:  err_q = '0;
      endcase
      adj      = (err_q < QC_W'(cfg.sjw)) ? err_q : QC_W'(cfg.sjw);
      last_q   = (qcnt + 1'b1) >= seg_len;
      seg_done = tick && last_q;
   end

   assign sample_pt = run && !hard_sync && seg_done && (seg == SEG_PH1);
   assign tx_pt     = run && !hard_sync && seg_done && (seg == SEG_PH2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg <= SEG_SYNC; qcnt <= '0; ext <= '0; shrink <= '0; done <= 1'b0;
      end else if (!run || hard_sync) begin
         seg <= SEG_SYNC; qcnt <= '0; ext <= '0; shrink <= '0; done <= 1'b0;
      end else begin
         if (resync) begin
            done <= 1'b1;
            if (seg == SEG_PH2) shrink <= adj;
            else                ext    <= adj;
         end
         if (seg_done) begin
            qcnt <= '0;
            unique case (seg)
               SEG_SYNC: seg <= SEG_PROP;
               SEG_PROP: seg <= SEG_PH1;
               SEG_PH1:  seg <= SEG_PH2;
               default: begin
                  seg    <= SEG_SYNC;
                  ext    <= '0;
                  shrink <= '0;
                  done   <= 1'b0;
               end
            endcase
         end else if (tick) begin
            qcnt <= qcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
   import cbt_pkg::*;
#(
   parameter int BRP_W          = 6,
   parameter int RX_SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             config_mode,
   input  logic [BRP_W-1:0] cfg_brp,
   input  logic [SEG_W-1:0] cfg_prop,
   input  logic [SEG_W-1:0] cfg_ph1,
   input  logic [SEG_W-1:0] cfg_ph2,
   input  logic [SEG_W-1:0] cfg_sjw,
   input  logic             rx,
   input  logic             bus_idle,
   output logic             sample_pt,
   output logic             tx_pt,
   output logic             config_error
);
   if (BRP_W < 1 || BRP_W > 12) begin : g_bad_brp_w
      $error("can_bit_timer: BRP_W must lie in 1..12");
   end
   if (RX_SYNC_STAGES == 1 || RX_SYNC_STAGES < 0) begin : g_bad_sync
      $error("can_bit_timer: RX_SYNC_STAGES must be 0 or at least 2");
   end

   seg_cfg_t         seg_in;
   seg_cfg_t         seg_q;
   logic [BRP_W-1:0] brp_q;
   logic             cfg_bad;
   logic             run;
   logic             tq_tick;
   logic             hard_sync;
   logic             rx_s;
   logic             rx_prev;
   logic             fall_edge;

   assign seg_in = '{prop: cfg_prop, ph1: cfg_ph1, ph2: cfg_ph2, sjw: cfg_sjw};

   if (RX_SYNC_STAGES == 0) begin : g_rx_direct
      assign rx_s = rx;
   end else begin : g_rx_sync
      logic [RX_SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '1;
         else        sr <= {sr[RX_SYNC_STAGES-2:0], rx};
      end
      assign rx_s = sr[RX_SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_prev <= 1'b1;
      else        rx_prev <= rx_s;
   end
   assign fall_edge = rx_prev && !rx_s;

   cbt_cfg_latch #(.BRP_W(BRP_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(config_mode),
      .brp_in(cfg_brp), .seg_in(seg_in),
      .brp_q(brp_q), .seg_q(seg_q), .bad(cfg_bad)
   );

   assign run          = !config_mode && !cfg_bad;
   assign config_error = cfg_bad;

   cbt_tq_div #(.BRP_W(BRP_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(hard_sync),
      .brp(brp_q), .tick(tq_tick)
   );

   cbt_seg_seq u_seq (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tq_tick),
      .fall_edge(fall_edge), .bus_idle(bus_idle), .cfg(seg_q),
      .hard_sync(hard_sync), .sample_pt(sample_pt), .tx_pt(tx_pt)
   );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
   input logic clk,
   input logic rst_n,
   input logic config_mode,
   input logic config_error,
   input logic sample_pt,
   input logic tx_pt,
   input logic tq_tick
);
   a_r4_quiet_in_config: assert property (@(posedge clk) disable iff (!rst_n)
      config_mode |-> (!sample_pt && !tx_pt));

   a_r4_quiet_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      config_error |-> (!sample_pt && !tx_pt));

   a_r11_never_together: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_pt && tx_pt));

   a_r11_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pt |=> !tx_pt);

   a_r11_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
      sample_pt |=> !sample_pt);

   a_r2_sample_on_quantum: assert property (@(posedge clk) disable iff (!rst_n)
      sample_pt |-> tq_tick);

   a_r1_tx_on_quantum: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pt |-> tq_tick);

   a_r5_error_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!config_mode && $past(!config_mode)) |-> $stable(config_error));
endmodule

bind can_bit_timer cbt_checker u_chk (
   .clk(clk), .rst_n(rst_n), .config_mode(config_mode),
   .config_error(config_error), .sample_pt(sample_pt), .tx_pt(tx_pt),
   .tq_tick(tq_tick)
);

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;
   localparam int BRP_W = 6;
   localparam int NROW  = 11;
   // columns: brp, prop, ph1, ph2, sjw, expected config_error
   localparam int TBL [NROW][6] = '{
      '{0, 2, 3, 3, 1, 0},
      '{1, 1, 4, 2, 1, 0},
      '{2, 8, 8, 8, 4, 0},
      '{0, 1, 3, 4, 1, 0},
      '{5, 2, 3, 3, 2, 0},
      '{0, 1, 2, 2, 1, 1},
      '{0, 0, 4, 4, 1, 1},
      '{0, 9, 4, 4, 1, 1},
      '{0, 1, 2, 5, 1, 1},
      '{0, 3, 3, 2, 2, 1},
      '{0, 3, 3, 3, 0, 1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             config_mode = 1'b0;
   logic [BRP_W-1:0] cfg_brp = '0;
   logic [3:0]       cfg_prop = '0, cfg_ph1 = '0, cfg_ph2 = '0, cfg_sjw = '0;
   logic             rx = 1'b1;
   logic             bus_idle = 1'b0;
   logic             sample_pt, tx_pt, config_error;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   can_bit_timer #(.BRP_W(BRP_W)) u_can_bit_timer (
      .clk(clk), .rst_n(rst_n), .config_mode(config_mode),
      .cfg_brp(cfg_brp), .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1),
      .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw), .rx(rx), .bus_idle(bus_idle),
      .sample_pt(sample_pt), .tx_pt(tx_pt), .config_error(config_error)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected<=150000", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load_cfg(input int b, input int p, input int a, input int c, input int s);
      @(negedge clk);
      config_mode = 1'b1;
      cfg_brp = BRP_W'(b); cfg_prop = 4'(p); cfg_ph1 = 4'(a); cfg_ph2 = 4'(c); cfg_sjw = 4'(s);
      repeat (3) @(negedge clk);
      config_mode = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // Align on a tx_pt, then count posedges to the next sample_pt and tx_pt.
   // rx falls at the negedge after posedge number fall_at and rises after rise_at.
   task automatic measure(input int fall_at, input int rise_at, output int t_smp, output int t_tx);
      int waited;
      t_smp = -1; t_tx = -1; waited = 0;
      @(negedge clk);
      while (!tx_pt && waited < 3000) begin
         @(negedge clk);
         waited++;
      end
      if (!tx_pt) return;
      for (int cnt = 1; cnt < 3000; cnt++) begin
         @(posedge clk);
         @(negedge clk);
         if (sample_pt && t_smp < 0) t_smp = cnt;
         if (tx_pt) begin
            t_tx = cnt;
            break;
         end
         if (cnt == fall_at) rx = 1'b0;
         if (cnt == rise_at) rx = 1'b1;
      end
      rx = 1'b1;
   endtask

   task automatic count_strobes(input int n, output int hits);
      hits = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (sample_pt || tx_pt) hits++;
      end
   endtask

   initial begin
      int ts, tt, hits, tq, nbt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6: reset state
      chk(config_error == 1'b1, "R6 config_error after reset", int'(config_error), 1);
      count_strobes(60, hits);
      chk(hits == 0, "R6 no strobes after reset", hits, 0);

      // R1 R2 R3 R4: table walk
      for (int r = 0; r < NROW; r++) begin
         load_cfg(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4]);
         chk(int'(config_error) == TBL[r][5], $sformatf("R3 row %0d config_error", r),
             int'(config_error), TBL[r][5]);
         if (TBL[r][5] == 1) begin
            count_strobes(300, hits);
            chk(hits == 0, $sformatf("R4 row %0d idle on error", r), hits, 0);
         end else begin
            tq  = 2 * (TBL[r][0] + 1);
            nbt = 1 + TBL[r][1] + TBL[r][2] + TBL[r][3];
            measure(-1, -1, ts, tt);
            chk(tt == nbt * tq, $sformatf("R1 row %0d bit period", r), tt, nbt * tq);
            chk(ts == (1 + TBL[r][1] + TBL[r][2]) * tq,
                $sformatf("R2 row %0d sample position", r), ts, (1 + TBL[r][1] + TBL[r][2]) * tq);
         end
      end

      // R5: inputs ignored while config_mode low
      load_cfg(0, 2, 3, 3, 1);
      @(negedge clk);
      cfg_brp = BRP_W'(2); cfg_prop = 4'd8; cfg_ph1 = 4'd8; cfg_ph2 = 4'd8; cfg_sjw = 4'd0;
      measure(-1, -1, ts, tt);
      chk(tt == 18, "R5 period unchanged by idle inputs", tt, 18);
      chk(config_error == 1'b0, "R5 config_error unchanged", int'(config_error), 0);

      // R4: config_mode keeps the block quiet
      load_cfg(0, 2, 3, 3, 1);
      @(negedge clk);
      config_mode = 1'b1;
      count_strobes(100, hits);
      chk(hits == 0, "R4 quiet while config_mode", hits, 0);
      config_mode = 1'b0;

      // R7: hard sync while idle (TQ=2, NBT=9)
      measure(-1, -1, ts, tt);
      repeat (5) @(posedge clk);
      @(negedge clk);
      bus_idle = 1'b1;
      rx = 1'b0;
      @(posedge clk);
      ts = -1; tt = -1;
      for (int cnt = 0; cnt < 200; cnt++) begin
         @(negedge clk);
         if (sample_pt && ts < 0) ts = cnt;
         if (tx_pt) begin
            tt = cnt;
            break;
         end
         @(posedge clk);
      end
      chk(ts == 11, "R7 sample after hard sync", ts, 11);
      chk(tt == 17, "R7 bit end after hard sync", tt, 17);
      rx = 1'b1;
      bus_idle = 1'b0;

      // Resync cases: brp 0, prop 2, ph1 3, ph2 3, sjw 2 -> TQ 2, NBT 9 (18 cycles)
      load_cfg(0, 2, 3, 3, 2);
      measure(3, 4, ts, tt);      // edge in first prop quantum: e=1
      chk(tt == 20, "R8 prop edge lengthens by 1", tt, 20);
      measure(7, 8, ts, tt);      // edge in first ph1 quantum: e=3 clipped to sjw
      chk(tt == 22, "R8 ph1 edge lengthens by sjw", tt, 22);
      chk(ts == 16, "R8 sample moves with ph1", ts, 16);
      measure(13, 14, ts, tt);    // edge in first ph2 quantum: r=3 clipped to sjw
      chk(tt == 14, "R9 ph2 edge shortens by sjw", tt, 14);
      measure(1, 2, ts, tt);      // edge in sync segment
      chk(tt == 18, "R10 sync edge no effect", tt, 18);
      rx = 1'b0;
      measure(-1, 7, ts, tt);     // rise only, in ph1
      chk(tt == 18, "R10 rising edge no effect", tt, 18);
      chk(ts == 12, "R10 sample unchanged on rise", ts, 12);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule